// File: doc/BRIEF.md
# I2C Register Target with Auto-Increment Pointer

This block is an I2C target that gives a host access to a small file of 8-bit registers through an 8-bit register pointer. A write transaction carries the pointer in its first byte. Every later byte is stored at the pointer and the pointer then moves up by one. A read that has no pointer phase of its own starts at the register most recently named by a pointer byte, and it steps forward each time the host acknowledges a byte. A repeated START can follow a pointer byte. This gives the random read form, and it also gives a combined write form in which the data bytes come after a second address phase.

The bus pins are sampled by the system clock. The block outputs an open-drain pull-down request (`sda_oe`) instead of driving the line itself. Bit 0 of the 7-bit target address comes from an external select pin, so two instances can share one bus. A chip-enable input blocks every response while it is low. The register contents are available in parallel on a flat output vector so that neighbouring logic can use them.

Top module: `i2cr_target`

## Requirements
- R1: The block takes a 7-bit address, MSB first, followed by an R/W bit (1 = read, 0 = write). It acknowledges, by pulling SDA low during the ninth clock, when the address equals `{TGT_ADDR[6:1], addr_sel}`. With the defaults this is 0x2C for `addr_sel`=0 and 0x2D for `addr_sel`=1.
- R2: The block does not acknowledge an address that differs from its own. It then leaves SDA released and the registers unchanged until the next START or STOP.
- R3: While `enable` is low the block never pulls SDA low and writes no register.
- R4: In a write transaction the first byte after the address loads the pointer. Each later byte is written to pointer, pointer+1 and so on, and every byte is acknowledged. The pointer wraps from 0xFF to 0x00.
- R5: A read that begins right after the address (with no pointer byte) returns the register named by the most recent pointer byte. Each host ACK moves it to the next register.
- R6: The sequence write-address, pointer, repeated START, read-address returns the register at that pointer.
- R7: After a pointer byte that is followed by a repeated START and a write address, the next bytes are data, written from the pointer upward. They do not load a new pointer.
- R8: A host NACK on a read byte ends data output. SDA stays released until the next START, and a STOP always releases SDA.
- R9: Pointer values at or above NUM_REGS (16 by default) address no register. Writes there are discarded and reads return 0x00.
- R10: `sda_oe` changes only while the synchronised SCL is low, and read bytes are sent MSB first.
- R11: After reset every register is 0x00, SDA is released and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Chip enable; low blocks all bus responses |
| addr_sel | input | 1 | Supplies bit 0 of the target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_q | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
SCL and SDA each pass through two synchroniser flops and one edge-detect flop. The block's response to an SCL fall therefore reaches `sda_oe` about four system clocks after the fall. A register write arrives one clock after that. The bench master holds every SCL phase for twelve clocks. It samples SDA in the middle of the SCL high phase and reads `reg_q` only after a STOP plus a settling gap, so every result is already stable when it is checked. Reads are compared with a bench model of the register file, including the pointer anchor and the out-of-range rule, which is updated by the same transactions.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int BYTE_W = 8;
   localparam int PTR_W  = 8;
   localparam int TADR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WRX,
      ST_WACK,
      ST_RTX,
      ST_RACK
   } bus_state_t;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_chk
      $error("i2cr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_prev, sda_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_prev <= scl_pipe[STAGES-1];
         sda_prev <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl   = scl_pipe[STAGES-1];
   assign sda_lvl   = sda_pipe[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile
   import i2cr_pkg::*;
#(
   parameter int NUM_REGS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [PTR_W-1:0]         wr_addr,
   input  logic [BYTE_W-1:0]        wr_data,
   input  logic [PTR_W-1:0]         rd_addr,
   output logic [BYTE_W-1:0]        rd_data,
   output logic [NUM_REGS*BYTE_W-1:0] reg_q
);
   if (NUM_REGS < 1 || NUM_REGS > (1 << PTR_W)) begin : g_chk
      $error("i2cr_regfile: NUM_REGS out of range");
   end

   logic [BYTE_W-1:0] mem [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (wr_en && wr_addr == PTR_W'(i))
            mem[i] <= wr_data;
      end
      assign reg_q[i*BYTE_W +: BYTE_W] = mem[i];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == PTR_W'(i)) rd_data = mem[i];
   end
endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
   import i2cr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [TADR_W-1:0] own_addr,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [PTR_W-1:0]  rd_addr,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_oe
);
   localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

   bus_state_t        state;
   logic [BYTE_W-1:0] shreg, txreg;
   logic [3:0]        bit_cnt;
   logic              is_read, expect_ptr, ptr_armed, host_ack;
   logic [PTR_W-1:0]  anchor, work;

   assign rd_addr = work;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         shreg      <= '0;
         txreg      <= '0;
         bit_cnt    <= '0;
         is_read    <= 1'b0;
         expect_ptr <= 1'b1;
         ptr_armed  <= 1'b0;
         host_ack   <= 1'b0;
         anchor     <= '0;
         work       <= '0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         sda_oe     <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (!enable) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            ptr_armed <= 1'b0;
         end else if (stop_det) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            ptr_armed <= 1'b0;
         end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                     if (shreg[BYTE_W-1:1] == own_addr) begin
                        state      <= ST_AACK;
                        sda_oe     <= 1'b1;
                        is_read    <= shreg[0];
                        expect_ptr <= ~ptr_armed;
                        if (shreg[0]) work <= anchor;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (is_read) begin
                        state  <= ST_RTX;
                        txreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        state  <= ST_WRX;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_WRX: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                     state  <= ST_WACK;
                     sda_oe <= 1'b1;
                     if (expect_ptr) begin
                        anchor     <= shreg;
                        work       <= shreg;
                        expect_ptr <= 1'b0;
                        ptr_armed  <= 1'b1;
                     end else begin
                        wr_en     <= 1'b1;
                        wr_addr   <= work;
                        wr_data   <= shreg;
                        work      <= work + 8'd1;
                        ptr_armed <= 1'b0;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     state   <= ST_WRX;
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                  end
               end
               ST_RTX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == BITS_PER_BYTE) begin
                        state  <= ST_RACK;
                        sda_oe <= 1'b0;
                     end else begin
                        txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txreg[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_lvl;
                     if (!sda_lvl) work <= work + 8'd1;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        state   <= ST_RTX;
                        bit_cnt <= '0;
                        txreg   <= rd_data;
                        sda_oe  <= ~rd_data[BYTE_W-1];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2cr_target.sv
module i2cr_target
   import i2cr_pkg::*;
#(
   parameter int               NUM_REGS    = 16,
   parameter logic [6:0]       TGT_ADDR    = 7'h2C,
   parameter bit               PIN_SEL_EN  = 1'b1,
   parameter int               SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enable,
   input  logic                       addr_sel,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   output logic [NUM_REGS*BYTE_W-1:0] reg_q
);
   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic [TADR_W-1:0] own_addr;
   logic              wr_en;
   logic [PTR_W-1:0]  wr_addr, rd_addr;
   logic [BYTE_W-1:0] wr_data, rd_data;

   if (PIN_SEL_EN) begin : g_pin_addr
      assign own_addr = {TGT_ADDR[6:1], addr_sel};
   end else begin : g_fixed_addr
      logic unused_sel;
      assign unused_sel = addr_sel;
      assign own_addr   = TGT_ADDR;
   end

   i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2cr_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(own_addr),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
      .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sda_oe(sda_oe)
   );

   i2cr_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .reg_q(reg_q)
   );
endmodule

// File: rtl/i2cr_target_chk.sv
module i2cr_target_chk #(
   parameter int NUM_REGS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  enable,
   input logic                  scl_lvl,
   input logic                  stop_det,
   input logic                  sda_oe,
   input logic [NUM_REGS*8-1:0] reg_q
);
   assert_sda_quiet_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !sda_oe);

   assert_regs_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && $past(!enable)) |-> $stable(reg_q));

   assert_sda_change_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

   assert_regs_write_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(reg_q));

   assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
endmodule

bind i2cr_target i2cr_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .scl_lvl(scl_lvl),
   .stop_det(stop_det), .sda_oe(sda_oe), .reg_q(reg_q)
);

// File: tb/i2cr_target_tb.sv
`timescale 1ns/1ps
module i2cr_target_tb;
   localparam int NREG = 16;
   localparam int Q    = 12;
   localparam int WDOG = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b1;
   logic addr_sel = 1'b0;
   logic scl = 1'b1;
   logic m_pull = 1'b0;
   logic sda_oe;
   logic [NREG*8-1:0] reg_q;
   wire  sda_bus = !(m_pull || sda_oe);

   int n_chk = 0, n_fail = 0;
   logic [7:0] model [256];
   logic [7:0] m_anchor = 8'h00;
   bit done = 1'b0;

   always #10 clk = ~clk;

   i2cr_target #(.NUM_REGS(NREG)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .addr_sel(addr_sel),
      .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe), .reg_q(reg_q)
   );

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      return (int'(a) < NREG) ? model[a] : 8'h00;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input bit pull, output bit smp);
      m_pull = pull; wt(Q);
      scl = 1'b1; wt(Q);
      smp = sda_bus; wt(Q);
      scl = 1'b0; wt(Q);
   endtask

   task automatic bus_start();
      m_pull = 1'b0; wt(Q);
      scl = 1'b1; wt(Q);
      m_pull = 1'b1; wt(Q);
      scl = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      m_pull = 1'b1; wt(Q);
      scl = 1'b1; wt(Q);
      m_pull = 1'b0; wt(4*Q);
   endtask

   task automatic send(input logic [7:0] b, output bit nack);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(!b[i], s);
      clk_bit(1'b0, nack);
   endtask

   task automatic recv(input bit ack, output logic [7:0] b);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b0, s);
         b[i] = s;
      end
      clk_bit(ack, s);
   endtask

   task automatic wr_seq(input logic [6:0] ta, input logic [7:0] ptr,
                         input int cnt, input logic [7:0] d0);
      bit nk;
      bus_start();
      send({ta, 1'b0}, nk); chk("R1 addr ack", nk, 0);
      send(ptr, nk);        chk("R4 ptr ack", nk, 0);
      m_anchor = ptr;
      for (int i = 0; i < cnt; i++) begin
         send(d0 + 8'(i), nk); chk("R4 data ack", nk, 0);
         if (int'(8'(ptr + 8'(i))) < NREG) model[8'(ptr + 8'(i))] = d0 + 8'(i);
      end
      bus_stop();
   endtask

   task automatic rd_plain(input int cnt, input string req);
      bit nk;
      logic [7:0] b, p;
      p = m_anchor;
      bus_start();
      send({7'h2C, 1'b1}, nk); chk("R1 read addr ack", nk, 0);
      for (int i = 0; i < cnt; i++) begin
         recv(i != cnt - 1, b);
         chk(req, b, exp_rd(p));
         p = p + 8'd1;
      end
      bus_stop();
   endtask

   task automatic chk_regs(input string req);
      for (int i = 0; i < NREG; i++) chk(req, reg_q[i*8 +: 8], model[i]);
   endtask

   initial begin
      bit nk;
      logic [7:0] b;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      wt(5); rst_n = 1'b1; wt(5);

      // R11 reset state
      chk("R11 sda released", sda_oe, 0);
      chk_regs("R11 regs zero");
      rd_plain(1, "R11 pointer zero");

      // R4 sequential write then R5 plain read from anchor
      wr_seq(7'h2C, 8'h03, 3, 8'hA5);
      chk_regs("R4 seq write");
      rd_plain(3, "R5 plain read");
      rd_plain(2, "R5 plain read again from anchor");

      // R6 random read
      wr_seq(7'h2C, 8'h05, 0, 8'h00);
      bus_start();
      send({7'h2C, 1'b0}, nk); send(8'h04, nk);
      bus_start();
      send({7'h2C, 1'b1}, nk); chk("R6 read addr ack", nk, 0);
      recv(1'b0, b); chk("R6 random read", b, exp_rd(8'h04));
      bus_stop();
      m_anchor = 8'h04;

      // R7 combined write
      bus_start();
      send({7'h2C, 1'b0}, nk); send(8'h09, nk);
      bus_start();
      send({7'h2C, 1'b0}, nk); chk("R7 second addr ack", nk, 0);
      send(8'h3C, nk); chk("R7 data ack", nk, 0);
      send(8'h3D, nk);
      bus_stop();
      model[9] = 8'h3C; model[10] = 8'h3D; m_anchor = 8'h09;
      chk("R7 reg9", reg_q[9*8 +: 8], 8'h3C);
      chk("R7 reg10", reg_q[10*8 +: 8], 8'h3D);

      // R2 wrong address
      bus_start();
      send({7'h2D, 1'b0}, nk); chk("R2 nack foreign addr", nk, 1);
      send(8'h00, nk); chk("R2 ignored byte", nk, 1);
      send(8'hFF, nk); chk("R2 ignored byte2", nk, 1);
      bus_stop();
      chk_regs("R2 regs untouched");

      // R1 select pin
      addr_sel = 1'b1; wt(4);
      bus_start(); send({7'h2C, 1'b0}, nk); bus_stop();
      chk("R1 sel=1 rejects 2C", nk, 1);
      wr_seq(7'h2D, 8'h01, 1, 8'h77);
      chk("R1 sel=1 write", reg_q[8 +: 8], 8'h77);
      addr_sel = 1'b0; wt(4);

      // R3 disabled
      enable = 1'b0; wt(4);
      bus_start();
      send({7'h2C, 1'b0}, nk); chk("R3 no ack disabled", nk, 1);
      send(8'h00, nk); send(8'h99, nk); chk("R3 no ack data", nk, 1);
      bus_stop();
      chk("R3 reg0 kept", reg_q[7:0], model[0]);
      enable = 1'b1; wt(4);

      // R8 master nack releases SDA
      bus_start();
      send({7'h2C, 1'b1}, nk);
      recv(1'b0, b); chk("R8 first byte", b, exp_rd(m_anchor));
      recv(1'b0, b); chk("R8 released after nack", b, 8'hFF);
      bus_stop();
      chk("R8 sda released after stop", sda_oe, 0);

      // R9 out of range and R4 wrap
      wr_seq(7'h2C, 8'h20, 1, 8'h55);
      chk_regs("R9 out-of-range write discarded");
      rd_plain(1, "R9 out-of-range read zero");
      wr_seq(7'h2C, 8'hFF, 2, 8'h10);
      chk("R4 wrap to reg0", reg_q[7:0], 8'h11);
      rd_plain(2, "R4 wrap read");

      // R10 bit order, random mix
      wr_seq(7'h2C, 8'h0C, 1, 8'h81);
      rd_plain(1, "R10 msb first 0x81");
      for (int it = 0; it < 14; it++) begin
         logic [7:0] p, d;
         int c;
         p = 8'($urandom_range(0, NREG + 3));
         d = 8'($urandom);
         c = $urandom_range(1, 3);
         wr_seq(7'h2C, p, c, d);
         rd_plain(c, "R5 random readback");
      end
      chk_regs("R4 final regs");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule